// File: doc/BRIEF.md
# Switch CPU Register Interface

This block connects a byte-wide synchronous processor bus to a time-slot switch. The address has one more bit than is needed to index a channel. With its top bit low, an access goes to a single internal control register. With its top bit high, the lower bits index one of 32 channel locations inside a memory window.

The control register chooses which memory that window reaches. The data memory holds received samples and is read-only from the bus. The connection memory has a low half, which holds source addresses or processor data, and a high half, which holds per-channel control. The register also chooses which stream's subsection is reached.

A split-memory flag changes how reads are routed. While it is set, reads always return data-memory contents and writes still go to the connection half that the selector names. A processor-enable flag is exported for the datapath, which uses it to force every output channel into processor mode with its driver enabled. The memories themselves are outside the block. It drives their request strobes and addresses and takes their read data combinationally in the strobe cycle.

Top module: `sw_cpu_regif`

## Requirements
- R1: After reset the control register is 0x00, `rdata_o` is 0, and `split_o` and `proc_en_o` are low.
- R2: A write with `cs_i` and `wr_i` high and `addr_i[5]`=0 stores the byte. Bit 5 is reserved and always stored as 0. From the next cycle, `split_o` shows bit 7 and `proc_en_o` shows bit 6.
- R3: A read with `cs_i` and `rd_i` high and `addr_i[5]`=0 places the stored control byte on `rdata_o` one clock after the strobe.
- R4: During a channel access (`addr_i[5]`=1), the memory address outputs are set as follows. `mem_chan_o` equals `addr_i[4:0]`. `mem_stream_o` equals control bits 2:0. `mem_wdata_o` equals `wdata_i`.
- R5: With memory select (control bits 4:3) = 10, channel reads pulse `cml_rd_o` and channel writes pulse `cml_wr_o`. Read data is `cml_rdata_i`, registered one clock later.
- R6: With memory select = 11, channel reads pulse `cmh_rd_o` and channel writes pulse `cmh_wr_o`. Read data is `cmh_rdata_i` one clock later.
- R7: With memory select = 00, channel reads pulse `dm_rd_o` and return `dm_rdata_i` one clock later. Channel writes raise no write strobe.
- R8: Memory select = 01 is reserved. A channel read raises no strobe and returns 0. A channel write raises no strobe.
- R9: With split-memory (control bit 7) set, every channel read pulses `dm_rd_o` and returns data-memory contents, whatever the memory select. Writes still follow the memory select.
- R10: No memory strobe is raised without `cs_i` and the matching `rd_i` or `wr_i`. At most one read strobe is high in any cycle.
- R11: `rdata_o` keeps its value in every cycle without a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 6 | Bit 5 selects channel space; bits 4:0 channel |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one clock after the strobe |
| split_o | output | 1 | Split-memory flag |
| proc_en_o | output | 1 | Processor-enable flag for the datapath |
| mem_stream_o | output | 3 | Stream subsection for memory accesses |
| mem_chan_o | output | 5 | Channel index for memory accesses |
| mem_wdata_o | output | 8 | Write data toward the connection memory |
| dm_rd_o | output | 1 | Data-memory read request |
| dm_rdata_i | input | 8 | Data-memory read data |
| cml_rd_o | output | 1 | Connection-low read request |
| cml_wr_o | output | 1 | Connection-low write request |
| cml_rdata_i | input | 8 | Connection-low read data |
| cmh_rd_o | output | 1 | Connection-high read request |
| cmh_wr_o | output | 1 | Connection-high write request |
| cmh_rdata_i | input | 8 | Connection-high read data |

## Verification
The assertions check several properties on every cycle:
- no strobe is raised without chip select;
- read strobes stay one-hot-or-idle;
- split mode always routes reads to the data memory;
- the data-memory and reserved selects never raise a write strobe;
- the flags follow a control write;
- registered read data matches the source sampled one cycle earlier;
- `rdata_o` holds while no read is made.

Only the bench scenarios can show two things. The first is that a value written through the window lands at the stream and channel it was aimed at and is read back from that place. The second is that register state built up over a sequence of mixed accesses gives the right routing for later ones.

// File: rtl/sw_regif_pkg.sv
package sw_regif_pkg;
  typedef enum logic [1:0] {
    SEL_DM   = 2'b00,
    SEL_RSVD = 2'b01,
    SEL_CML  = 2'b10,
    SEL_CMH  = 2'b11
  } mem_sel_e;

  // Field positions are decoded by the datapath and by software.
  typedef struct packed {
    logic     split;
    logic     proc_en;
    logic     rsvd;
    mem_sel_e sel;
    logic [2:0] stream;
  } ctrl_t;

  localparam int unsigned CTRL_W   = $bits(ctrl_t);
  localparam int unsigned STREAM_W = 3;
endpackage

// File: rtl/sw_ctrl_reg.sv
module sw_ctrl_reg
  import sw_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i) begin
      ctrl_q      <= ctrl_t'(wdata_i);
      ctrl_q.rsvd <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;

  // R2
  ctrl_flags_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ctrl_o.split == $past(wdata_i[7]) && ctrl_o.proc_en == $past(wdata_i[6])));
endmodule

// File: rtl/sw_addr_decode.sv
module sw_addr_decode
  import sw_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  ctrl_t             ctrl_i,
  output logic              ctrl_we_o,
  output logic              ctrl_re_o,
  output logic              dm_rd_o,
  output logic              cml_rd_o,
  output logic              cml_wr_o,
  output logic              cmh_rd_o,
  output logic              cmh_wr_o,
  output logic              rsvd_re_o
);
  localparam int unsigned SPACE_BIT = ADDR_W - 1;

  logic chan_sp, ch_rd, ch_wr;

  assign chan_sp   = addr_i[SPACE_BIT];
  assign ch_rd     = cs_i & rd_i & chan_sp;
  assign ch_wr     = cs_i & wr_i & chan_sp;
  assign ctrl_we_o = cs_i & wr_i & ~chan_sp;
  assign ctrl_re_o = cs_i & rd_i & ~chan_sp;

  always_comb begin
    dm_rd_o   = 1'b0;
    cml_rd_o  = 1'b0;
    cmh_rd_o  = 1'b0;
    rsvd_re_o = 1'b0;
    if (ch_rd) begin
      if (ctrl_i.split) dm_rd_o = 1'b1;
      else begin
        unique case (ctrl_i.sel)
          SEL_DM:   dm_rd_o   = 1'b1;
          SEL_CML:  cml_rd_o  = 1'b1;
          SEL_CMH:  cmh_rd_o  = 1'b1;
          default:  rsvd_re_o = 1'b1;
        endcase
      end
    end
  end

  // Data memory is read-only from the bus; reserved select is dropped.
  assign cml_wr_o = ch_wr & (ctrl_i.sel == SEL_CML);
  assign cmh_wr_o = ch_wr & (ctrl_i.sel == SEL_CMH);

  // R10
  rd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dm_rd_o, cml_rd_o, cmh_rd_o}));
  // R10
  no_strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> !(dm_rd_o | cml_rd_o | cmh_rd_o | cml_wr_o | cmh_wr_o));
  // R9
  split_reads_dm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.split && cs_i && rd_i && chan_sp) |-> dm_rd_o);
  // R7 R8
  no_dm_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.sel inside {SEL_DM, SEL_RSVD}) |-> !(cml_wr_o | cmh_wr_o));
endmodule

// File: rtl/sw_rdata_mux.sv
module sw_rdata_mux
  import sw_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_re_i,
  input  logic              dm_re_i,
  input  logic              cml_re_i,
  input  logic              cmh_re_i,
  input  logic              rsvd_re_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] dm_rdata_i,
  input  logic [DATA_W-1:0] cml_rdata_i,
  input  logic [DATA_W-1:0] cmh_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              any_re;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  assign any_re = ctrl_re_i | dm_re_i | cml_re_i | cmh_re_i | rsvd_re_i;

  always_comb begin
    rdata_d = '0;
    if (ctrl_re_i)     rdata_d = DATA_W'(ctrl_i);
    else if (dm_re_i)  rdata_d = dm_rdata_i;
    else if (cml_re_i) rdata_d = cml_rdata_i;
    else if (cmh_re_i) rdata_d = cmh_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (any_re) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_re |=> $stable(rdata_o));
  // R5
  cml_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cml_re_i |=> rdata_o == $past(cml_rdata_i));
  // R8
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_re_i |=> rdata_o == '0);
endmodule

// File: rtl/sw_cpu_regif.sv
module sw_cpu_regif
  import sw_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CHAN_W = ADDR_W - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                split_o,
  output logic                proc_en_o,
  output logic [STREAM_W-1:0] mem_stream_o,
  output logic [CHAN_W-1:0]   mem_chan_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                dm_rd_o,
  input  logic [DATA_W-1:0]   dm_rdata_i,
  output logic                cml_rd_o,
  output logic                cml_wr_o,
  input  logic [DATA_W-1:0]   cml_rdata_i,
  output logic                cmh_rd_o,
  output logic                cmh_wr_o,
  input  logic [DATA_W-1:0]   cmh_rdata_i
);
  ctrl_t ctrl;
  logic  ctrl_we, ctrl_re, rsvd_re;

  sw_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .wdata_i (wdata_i[CTRL_W-1:0]),
    .ctrl_o  (ctrl)
  );

  sw_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .ctrl_i    (ctrl),
    .ctrl_we_o (ctrl_we),
    .ctrl_re_o (ctrl_re),
    .dm_rd_o   (dm_rd_o),
    .cml_rd_o  (cml_rd_o),
    .cml_wr_o  (cml_wr_o),
    .cmh_rd_o  (cmh_rd_o),
    .cmh_wr_o  (cmh_wr_o),
    .rsvd_re_o (rsvd_re)
  );

  sw_rdata_mux #(.DATA_W(DATA_W)) u_rmux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_re_i   (ctrl_re),
    .dm_re_i     (dm_rd_o),
    .cml_re_i    (cml_rd_o),
    .cmh_re_i    (cmh_rd_o),
    .rsvd_re_i   (rsvd_re),
    .ctrl_i      (ctrl),
    .dm_rdata_i  (dm_rdata_i),
    .cml_rdata_i (cml_rdata_i),
    .cmh_rdata_i (cmh_rdata_i),
    .rdata_o     (rdata_o)
  );

  assign split_o      = ctrl.split;
  assign proc_en_o    = ctrl.proc_en;
  assign mem_stream_o = ctrl.stream;
  assign mem_chan_o   = addr_i[CHAN_W-1:0];
  assign mem_wdata_o  = wdata_i;

  // R6
  cmh_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmh_rd_o |=> rdata_o == $past(cmh_rdata_i));
  // R3
  ctrl_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && !wr_i && !addr_i[ADDR_W-1]) |=>
      rdata_o == DATA_W'({$past(split_o), $past(proc_en_o), 1'b0,
                          $past(ctrl.sel), $past(mem_stream_o)}));
endmodule

// File: tb/sw_cpu_regif_bench.sv
module sw_cpu_regif_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       split, pe;
  logic [2:0] stream;
  logic [4:0] chan;
  logic [7:0] mwdata;
  logic       dm_rd, cml_rd, cml_wr, cmh_rd, cmh_wr;
  logic [7:0] dm_rdata, cml_rdata, cmh_rdata;

  logic [7:0] dm_m  [256];
  logic [7:0] cml_m [256];
  logic [7:0] cmh_m [256];

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_ctrl = 8'h00;
  logic [7:0] exp_rdata = 8'h00;

  always #4 clk = ~clk;

  sw_cpu_regif u_sw_cpu_regif (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .split_o(split), .proc_en_o(pe), .mem_stream_o(stream),
    .mem_chan_o(chan), .mem_wdata_o(mwdata),
    .dm_rd_o(dm_rd), .dm_rdata_i(dm_rdata),
    .cml_rd_o(cml_rd), .cml_wr_o(cml_wr), .cml_rdata_i(cml_rdata),
    .cmh_rd_o(cmh_rd), .cmh_wr_o(cmh_wr), .cmh_rdata_i(cmh_rdata)
  );

  assign dm_rdata  = dm_m[{stream, chan}];
  assign cml_rdata = cml_m[{stream, chan}];
  assign cmh_rdata = cmh_m[{stream, chan}];

  always @(posedge clk) begin
    if (cml_wr) cml_m[{stream, chan}] <= mwdata;
    if (cmh_wr) cmh_m[{stream, chan}] <= mwdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {cmh, cml, dm}
  function automatic logic [2:0] exp_rd(input logic [7:0] c, input logic s, r, input logic [5:0] a);
    if (!(s && r && a[5])) return 3'b000;
    if (c[7]) return 3'b001;
    case (c[4:3])
      2'b00:   return 3'b001;
      2'b10:   return 3'b010;
      2'b11:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  // {cmh, cml}
  function automatic logic [1:0] exp_wr(input logic [7:0] c, input logic s, w, input logic [5:0] a);
    if (!(s && w && a[5])) return 2'b00;
    case (c[4:3])
      2'b10:   return 2'b01;
      2'b11:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic access(input logic s, r, w, input logic [5:0] a, input logic [7:0] d);
    logic [2:0] er;
    logic [1:0] ew;
    logic [7:0] idx;
    @(negedge clk);
    cs = s; rd = r; wr = w; addr = a; wdata = d;
    #1;
    er  = exp_rd(exp_ctrl, s, r, a);
    ew  = exp_wr(exp_ctrl, s, w, a);
    idx = {exp_ctrl[2:0], a[4:0]};
    check("R10 read strobes", {cmh_rd, cml_rd, dm_rd}, er);
    check("R5/R6 R7 write strobes", {cmh_wr, cml_wr}, ew);
    if (a[5]) begin
      check("R4 channel/stream", {stream, chan}, idx);
      check("R4 write data", mwdata, d);
    end
    if (s && r) begin
      if (!a[5])          exp_rdata = exp_ctrl;
      else if (er[0])     exp_rdata = dm_m[idx];
      else if (er[1])     exp_rdata = cml_m[idx];
      else if (er[2])     exp_rdata = cmh_m[idx];
      else                exp_rdata = 8'h00;
    end
    @(negedge clk);
    if (s && w && !a[5]) exp_ctrl = d & 8'hDF;
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
    check("R3 R5 R11 rdata", rdata, exp_rdata);
    check("R2 flags", {split, pe}, exp_ctrl[7:6]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd13579;
    void'($urandom(seed));
    for (int i = 0; i < 256; i++) begin
      dm_m[i]  = 8'(i * 7 + 3);
      cml_m[i] = 8'(i ^ 8'h5C);
      cmh_m[i] = 8'(i + 8'h21);
    end
    repeat (3) @(negedge clk);
    // R1
    check("R1 rdata reset", rdata, 8'h00);
    check("R1 flags reset", {split, pe}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stream reset", stream, 3'd0);

    // R2 R3 reserved bit 5
    access(1, 0, 1, 6'h00, 8'hFF);
    access(1, 1, 0, 6'h00, 8'h00);
    check("R2 rsvd bit", rdata, 8'hDF);
    // R5 connection low, stream 5
    access(1, 0, 1, 6'h00, 8'h15);
    access(1, 0, 1, 6'h27, 8'h5A);
    access(1, 1, 0, 6'h27, 8'h00);
    check("R5 cml readback", rdata, 8'h5A);
    // R6 connection high, stream 2
    access(1, 0, 1, 6'h00, 8'h1A);
    access(1, 0, 1, 6'h3F, 8'hC3);
    access(1, 1, 0, 6'h3F, 8'h00);
    check("R6 cmh readback", rdata, 8'hC3);
    // R7 data memory write ignored, stream 1
    access(1, 0, 1, 6'h00, 8'h01);
    access(1, 0, 1, 6'h20, 8'hEE);
    access(1, 1, 0, 6'h20, 8'h00);
    check("R7 dm read", rdata, 8'(8'd32 * 7 + 3));
    // R8 reserved select
    access(1, 0, 1, 6'h00, 8'h0B);
    access(1, 0, 1, 6'h21, 8'h77);
    access(1, 1, 0, 6'h21, 8'h00);
    check("R8 rsvd read zero", rdata, 8'h00);
    // R9 split with cml select: read dm, write cml
    access(1, 0, 1, 6'h00, 8'h93);
    access(1, 0, 1, 6'h22, 8'hA5);
    access(1, 1, 0, 6'h22, 8'h00);
    check("R9 split read dm", rdata, 8'(8'd98 * 7 + 3));
    access(1, 0, 1, 6'h00, 8'h13);
    access(1, 1, 0, 6'h22, 8'h00);
    check("R9 split wrote cml", rdata, 8'hA5);
    // R10 no chip select
    access(0, 1, 1, 6'h25, 8'h44);

    for (int i = 0; i < 600; i++) begin
      int unsigned op;
      logic [5:0] a;
      logic [7:0] d;
      op = $urandom_range(0, 9);
      a  = 6'($urandom);
      d  = 8'($urandom);
      case (op)
        0, 1:    access(1, 0, 1, {1'b0, a[4:0]}, d);
        2:       access(1, 1, 0, {1'b0, a[4:0]}, d);
        3, 4, 5: access(1, 1, 0, {1'b1, a[4:0]}, d);
        6, 7:    access(1, 0, 1, {1'b1, a[4:0]}, d);
        8:       access(0, op[0], ~op[0], a, d);
        default: access(1, 0, 0, a, d);
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule